// File: doc/BRIEF.md
# Instruction Fetch Sampling Unit

This block sits beside a processor front end and picks individual fetches for profiling. A programmable period sets how many fetches must be delivered to the decoder before the unit arms itself. Once armed, it tags the next fetch attempt and follows that one fetch until it ends. The fetch may end by being delivered or by being aborted, for example on a page fault. While the fetch is in flight the unit counts its latency in cycles and the cycles spent on a translation refill. At the end it latches a sample record and raises a level interrupt. The record holds the fetch address, the outcome, both latencies, the two instruction-cache hit flags, the two translation-buffer hit flags and the page size.

Software reads the record from the output ports and then acknowledges it. The acknowledge clears the record and starts a new counting period. Writing a period reloads it and restarts counting, and a period of zero keeps the unit idle. The front end is assumed to have at most one fetch in flight. Each end strobe (`fetch_done` or `fetch_abort`) closes the most recent `fetch_start`, and it arrives at least one cycle after that start.

Top module: `fetch_sampler`

## Requirements
- R1: After reset `rec_valid` and `irq` are 0, and every record output is 0.
- R2: While counting, only `fetch_done` advances the period count. `fetch_abort` never advances it.
- R3: With period N nonzero, the unit arms in the cycle of the N-th delivered fetch. The first `fetch_start` in a later cycle is tagged. Fetches started before that cycle, including the N-th, produce no record.
- R4: A tagged fetch ends on `fetch_done` or `fetch_abort`. In the following cycle `rec_valid` is 1. `rec_ok` is 1 when `fetch_done` was high at the end, and 0 when only `fetch_abort` was high.
- R5: `rec_lat` equals k, where the tagged start was in cycle t and the end in cycle t+k. The value saturates at 2^LAT_W-1.
- R6: `rec_addr` is the `fetch_addr` value in the tagged start cycle. The flags `rec_ic_l1`, `rec_ic_l2`, `rec_tlb_l1`, `rec_tlb_l2` and the 2-bit `rec_page` hold the values of their inputs in the end cycle, where 1 means hit.
- R7: `rec_refill` counts the cycles t+1 through t+k in which `refill_busy` is high, saturating at 2^LAT_W-1. It reads 0 when `tlb_l1_hit` was 1 in the end cycle.
- R8: `irq` equals `rec_valid`. While `rec_valid` is 1 the record does not change, and further fetches are neither counted nor tagged.
- R9: `ack` while `rec_valid` is 1 clears it in the next cycle and restarts the count from zero. `ack` while `rec_valid` is 0 has no effect, and the count is kept.
- R10: `cfg_wr` loads `cfg_period`, clears the count, and drops any armed state or tag that is in flight. A period of 0 never arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Period write strobe |
| cfg_period | input | PER_W | New period value |
| ack | input | 1 | Record acknowledge / re-arm |
| fetch_start | input | 1 | A fetch attempt begins this cycle |
| fetch_addr | input | ADDR_W | Address of the starting fetch |
| fetch_done | input | 1 | Fetch delivered to the decoder |
| fetch_abort | input | 1 | Fetch aborted |
| ic_l1_hit | input | 1 | L1 instruction-cache hit |
| ic_l2_hit | input | 1 | L2 cache hit |
| tlb_l1_hit | input | 1 | L1 translation-buffer hit |
| tlb_l2_hit | input | 1 | L2 translation-buffer hit |
| page_size | input | 2 | Translation page-size code |
| refill_busy | input | 1 | Translation refill in progress |
| irq | output | 1 | Level interrupt, sample pending |
| rec_valid | output | 1 | Record holds a sample |
| rec_ok | output | 1 | Fetch was delivered (not aborted) |
| rec_lat | output | LAT_W | Fetch latency in cycles |
| rec_refill | output | LAT_W | Refill latency in cycles |
| rec_addr | output | ADDR_W | Sampled fetch address |
| rec_ic_l1 | output | 1 | Captured L1 cache hit |
| rec_ic_l2 | output | 1 | Captured L2 cache hit |
| rec_tlb_l1 | output | 1 | Captured L1 translation hit |
| rec_tlb_l2 | output | 1 | Captured L2 translation hit |
| rec_page | output | 2 | Captured page-size code |

## Verification
Some properties are checked by the assertions on every cycle. Latency counters hold at their maximum and otherwise step by one. A tracked fetch that ends always yields a valid record. The record stays frozen until it is acknowledged, and an acknowledge clears it. A zero period keeps the unit counting without ever arming. Other behaviour can only be shown by the bench's scenarios. This includes which fetch gets tagged after exactly N deliveries, and the fact that aborts do not count. It also covers the exact latency and refill values, and the effect of a period write in mid-count or mid-flight. The bench sweeps the period, the fetch length (past saturation), the end kind and every flag combination.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRACK = 2'd2,
    ST_HOLD  = 2'd3
  } fs_state_e;

  typedef struct packed {
    logic       ic_l1;
    logic       ic_l2;
    logic       tlb_l1;
    logic       tlb_l2;
    logic [1:0] page;
  } fs_flags_t;
endpackage

// File: rtl/fs_period_ctr.sv
module fs_period_ctr #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [PER_W-1:0] period,
  output logic             reached
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W:0]   sum;

  assign sum     = {1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1};
  assign reached = step && (sum >= {1'b0, period});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (reached) cnt_d = '0;
    else if (step)    cnt_d = sum[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fs_sat_ctr.sv
module fs_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assign nxt = (inc && (cnt != MAXV)) ? cnt + {{(W-1){1'b0}}, 1'b1} : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= nxt;
  end

  // R5: counter holds at its maximum instead of wrapping
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cnt == MAXV) |=> cnt == MAXV);
  // R5: below the maximum, each counted cycle adds exactly one
  p_sat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && inc && cnt != MAXV) |=> cnt == $past(cnt) + {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/fs_record.sv
module fs_record
  import fs_pkg::*;
#(
  parameter int LAT_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              clear,
  input  logic              in_ok,
  input  logic [LAT_W-1:0]  in_lat,
  input  logic [LAT_W-1:0]  in_refill,
  input  logic [ADDR_W-1:0] in_addr,
  input  fs_flags_t         in_flags,
  output logic              valid,
  output logic              ok,
  output logic [LAT_W-1:0]  lat,
  output logic [LAT_W-1:0]  refill,
  output logic [ADDR_W-1:0] addr,
  output fs_flags_t         flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid <= 1'b0;
    else if (clear)   valid <= 1'b0;
    else if (capture) valid <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok     <= 1'b0;
      lat    <= '0;
      refill <= '0;
      addr   <= '0;
      flags  <= '0;
    end else if (capture) begin
      ok     <= in_ok;
      lat    <= in_lat;
      refill <= in_refill;
      addr   <= in_addr;
      flags  <= in_flags;
    end
  end

  // R8: a held record is frozen until acknowledged
  p_rec_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clear) |=> (valid && $stable({ok, lat, refill, addr, flags})));
endmodule

// File: rtl/fetch_sampler.sv
module fetch_sampler
  import fs_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int LAT_W  = 12,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic              ack,
  input  logic              fetch_start,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_done,
  input  logic              fetch_abort,
  input  logic              ic_l1_hit,
  input  logic              ic_l2_hit,
  input  logic              tlb_l1_hit,
  input  logic              tlb_l2_hit,
  input  logic [1:0]        page_size,
  input  logic              refill_busy,
  output logic              irq,
  output logic              rec_valid,
  output logic              rec_ok,
  output logic [LAT_W-1:0]  rec_lat,
  output logic [LAT_W-1:0]  rec_refill,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              rec_ic_l1,
  output logic              rec_ic_l2,
  output logic              rec_tlb_l1,
  output logic              rec_tlb_l2,
  output logic [1:0]        rec_page
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  fs_state_e        st_q, st_d;
  logic [PER_W-1:0] period_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic             tracking, tag_go, fetch_end, rearm;
  logic             step, reached;
  logic [LAT_W-1:0] lat_cnt, lat_nxt, ref_cnt, ref_nxt, ref_rec;
  fs_flags_t        end_flags, rec_flags;

  assign tracking  = (st_q == ST_TRACK);
  assign tag_go    = (st_q == ST_ARMED) && fetch_start && !cfg_wr;
  assign fetch_end = tracking && (fetch_done || fetch_abort) && !cfg_wr;
  assign rearm     = (st_q == ST_HOLD) && ack;
  assign step      = (st_q == ST_COUNT) && fetch_done && !cfg_wr && (period_q != '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_COUNT: if (reached)        st_d = ST_ARMED;
      ST_ARMED: if (cfg_wr)         st_d = ST_COUNT;
                else if (tag_go)    st_d = ST_TRACK;
      ST_TRACK: if (cfg_wr)         st_d = ST_COUNT;
                else if (fetch_end) st_d = ST_HOLD;
      ST_HOLD:  if (ack)            st_d = ST_COUNT;
      default:                      st_d = ST_COUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= ST_COUNT;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      period_q <= '0;
    else if (cfg_wr) period_q <= cfg_period;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      pend_addr_q <= '0;
    else if (tag_go) pend_addr_q <= fetch_addr;
  end

  fs_period_ctr #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst_n(rst_q), .clr(cfg_wr || rearm), .step(step),
    .period(period_q), .reached(reached)
  );

  fs_sat_ctr #(.W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_q), .clr(tag_go), .en(tracking),
    .inc(1'b1), .cnt(lat_cnt), .nxt(lat_nxt)
  );

  fs_sat_ctr #(.W(LAT_W)) u_refill (
    .clk(clk), .rst_n(rst_q), .clr(tag_go), .en(tracking),
    .inc(refill_busy), .cnt(ref_cnt), .nxt(ref_nxt)
  );

  assign end_flags = '{ic_l1: ic_l1_hit, ic_l2: ic_l2_hit, tlb_l1: tlb_l1_hit,
                       tlb_l2: tlb_l2_hit, page: page_size};
  assign ref_rec   = tlb_l1_hit ? '0 : ref_nxt;

  fs_record #(.LAT_W(LAT_W), .ADDR_W(ADDR_W)) u_rec (
    .clk(clk), .rst_n(rst_q), .capture(fetch_end), .clear(rearm),
    .in_ok(fetch_done), .in_lat(lat_nxt), .in_refill(ref_rec),
    .in_addr(pend_addr_q), .in_flags(end_flags),
    .valid(rec_valid), .ok(rec_ok), .lat(rec_lat), .refill(rec_refill),
    .addr(rec_addr), .flags(rec_flags)
  );

  assign irq        = rec_valid;
  assign rec_ic_l1  = rec_flags.ic_l1;
  assign rec_ic_l2  = rec_flags.ic_l2;
  assign rec_tlb_l1 = rec_flags.tlb_l1;
  assign rec_tlb_l2 = rec_flags.tlb_l2;
  assign rec_page   = rec_flags.page;

  // R4: a tracked fetch that ends yields a valid record next cycle
  p_end_capture_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (tracking && (fetch_done || fetch_abort) && !cfg_wr) |=> rec_valid);
  // R9: acknowledge of a held record clears it
  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (rec_valid && ack) |=> !rec_valid);
  // R8: a held record blocks counting and tagging
  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_q)
    rec_valid |-> (st_q == ST_HOLD));
  // R10: a zero period never arms
  p_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_COUNT && period_q == '0 && !cfg_wr) |=> (st_q == ST_COUNT));
endmodule

// File: tb/tb_fetch_sampler.sv
module tb_fetch_sampler;
  localparam int PW = 4, LW = 4, AW = 8;
  localparam int MAXL = (1 << LW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, ack = 0, fetch_start = 0, fetch_done = 0, fetch_abort = 0;
  logic [PW-1:0] cfg_period = '0;
  logic [AW-1:0] fetch_addr = '0;
  logic ic_l1_hit = 0, ic_l2_hit = 0, tlb_l1_hit = 0, tlb_l2_hit = 0, refill_busy = 0;
  logic [1:0] page_size = 2'd0;
  logic irq, rec_valid, rec_ok, rec_ic_l1, rec_ic_l2, rec_tlb_l1, rec_tlb_l2;
  logic [LW-1:0] rec_lat, rec_refill;
  logic [AW-1:0] rec_addr;
  logic [1:0] rec_page;
  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  fetch_sampler #(.PER_W(PW), .LAT_W(LW), .ADDR_W(AW)) dut (
    .clk, .rst_n, .cfg_wr, .cfg_period, .ack, .fetch_start, .fetch_addr,
    .fetch_done, .fetch_abort, .ic_l1_hit, .ic_l2_hit, .tlb_l1_hit, .tlb_l2_hit,
    .page_size, .refill_busy, .irq, .rec_valid, .rec_ok, .rec_lat, .rec_refill,
    .rec_addr, .rec_ic_l1, .rec_ic_l2, .rec_tlb_l1, .rec_tlb_l2, .rec_page
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_period(int p);
    cfg_wr = 1; cfg_period = PW'(p); tick(); cfg_wr = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic plain_fetch(int addr, bit good, int len);
    fetch_start = 1; fetch_addr = AW'(addr); tick(); fetch_start = 0;
    repeat (len - 1) tick();
    if (good) fetch_done = 1; else fetch_abort = 1;
    tick(); fetch_done = 0; fetch_abort = 0;
  endtask

  task automatic tag_fetch(int addr, bit good, bit both, int len, int rcy, int fl);
    fetch_start = 1; fetch_addr = AW'(addr); tick(); fetch_start = 0;
    for (int j = 1; j <= len; j++) begin
      refill_busy = (j <= rcy);
      if (j == len) begin
        fetch_done = good || both; fetch_abort = !good || both;
        ic_l1_hit = fl[0]; ic_l2_hit = fl[1]; tlb_l1_hit = fl[2];
        tlb_l2_hit = fl[3]; page_size = fl[5:4];
      end
      tick();
    end
    fetch_done = 0; fetch_abort = 0; refill_busy = 0;
    ic_l1_hit = 0; ic_l2_hit = 0; tlb_l1_hit = 0; tlb_l2_hit = 0; page_size = 0;
  endtask

  initial begin
    int lens[6] = '{1, 2, 5, 15, 16, 20};
    int idx = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 valid", rec_valid, 0); chk("R1 irq", irq, 0);
    chk("R1 lat", rec_lat, 0); chk("R1 addr", rec_addr, 0);
    chk("R1 flags", {rec_ok, rec_ic_l1, rec_ic_l2, rec_tlb_l1, rec_tlb_l2, rec_page}, 0);

    // main sweep
    for (int p = 1; p <= 4; p++)
      for (int li = 0; li < 6; li++)
        for (int e = 0; e < 2; e++) begin
          int len = lens[li];
          int rcy = (len > 3) ? len - 2 : len;
          int fl = idx % 64;
          int exp_ref = fl[2] ? 0 : ((rcy > MAXL) ? MAXL : rcy);
          int exp_lat = (len > MAXL) ? MAXL : len;
          int addr = 8'h80 + idx;
          set_period(p);
          for (int k = 1; k <= p; k++) begin
            plain_fetch(8'h10 + k, 0, 1);   // aborts never count (R2)
            plain_fetch(8'h20 + k, 1, 2);
          end
          chk("R3 nth fetch untagged", rec_valid, 0);
          tag_fetch(addr, e == 0, 0, len, rcy, fl);
          chk("R4 valid", rec_valid, 1);
          chk("R4 ok", rec_ok, e == 0);
          chk("R8 irq", irq, 1);
          chk("R5 lat", rec_lat, exp_lat);
          chk("R7 refill", rec_refill, exp_ref);
          chk("R6 addr", rec_addr, addr % 256);
          chk("R6 flags", {rec_page, rec_tlb_l2, rec_tlb_l1, rec_ic_l2, rec_ic_l1}, fl);
          plain_fetch(8'h33, 1, 1); plain_fetch(8'h34, 0, 3);
          chk("R8 lat held", rec_lat, exp_lat);
          chk("R8 addr held", rec_addr, addr % 256);
          do_ack();
          chk("R9 cleared", rec_valid, 0);
          chk("R9 irq low", irq, 0);
          idx++;
        end

    // R2: aborts alone never arm
    set_period(2);
    repeat (5) plain_fetch(8'h40, 0, 1);
    plain_fetch(8'h41, 1, 1);
    plain_fetch(8'h42, 1, 1);       // second delivery: arms, not tagged
    chk("R2 aborts not counted", rec_valid, 0);
    tag_fetch(8'h43, 1, 0, 3, 0, 4);
    chk("R2 tag after two deliveries", rec_addr, 8'h43);
    // R4: done and abort together count as delivered
    chk("R4 first ok", rec_ok, 1);
    do_ack();
    set_period(1);
    plain_fetch(8'h44, 1, 1);
    tag_fetch(8'h45, 0, 1, 2, 0, 4);
    chk("R4 both strobes ok", rec_ok, 1);
    do_ack();

    // R9: ack without record keeps the count
    set_period(3);
    plain_fetch(8'h50, 1, 1); plain_fetch(8'h51, 1, 1);
    do_ack();
    plain_fetch(8'h52, 1, 1);
    tag_fetch(8'h53, 1, 0, 1, 0, 4);
    chk("R9 stray ack ignored", rec_valid, 1);
    chk("R9 stray ack addr", rec_addr, 8'h53);
    do_ack();

    // R10: period write mid-count restarts the count
    set_period(3);
    plain_fetch(8'h60, 1, 1); plain_fetch(8'h61, 1, 1);
    set_period(3);
    plain_fetch(8'h62, 1, 1); plain_fetch(8'h63, 1, 1);
    plain_fetch(8'h64, 1, 1);
    chk("R10 reload restarts count", rec_valid, 0);
    tag_fetch(8'h65, 1, 0, 1, 0, 4);
    chk("R10 tag after reload", rec_addr, 8'h65);
    do_ack();

    // R10: period write during a tracked fetch drops the tag
    set_period(1);
    plain_fetch(8'h70, 1, 1);
    fetch_start = 1; fetch_addr = 8'h71; tick(); fetch_start = 0;
    cfg_wr = 1; cfg_period = 4'd2; tick(); cfg_wr = 0;
    fetch_done = 1; tick(); fetch_done = 0;
    tick();
    chk("R10 tag dropped", rec_valid, 0);

    // R10: zero period never arms
    set_period(0);
    repeat (6) plain_fetch(8'h72, 1, 1);
    tag_fetch(8'h73, 1, 0, 2, 0, 4);
    chk("R10 zero period idle", rec_valid, 0);
    chk("R10 zero period irq", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule